// File: doc/BRIEF.md
# Reset Controller with Power-Up Timer

This block merges eight independent reset requests into one chip-wide reset, `chip_rst_n`, and keeps a sticky record of which requests have occurred. The requests are an active-low external reset pin, power-on and brown-out detector pulses, a watchdog time-out, a software reset strobe, a configuration mismatch flag, and stack full and stack underflow events. The analog detectors, the oscillator and the regulator are outside the block and reach it only as digital levels or pulses. Every request must stay active for at least one clock period.

Any request pulls the chip reset low at once, without waiting for a clock edge. The reset is released on a clock edge once every request has gone away. After power-on, a power-up timer keeps the chip in reset for 2048 ticks of a slow tick. The tick is made by dividing the clock by `TICK_DIV`.

An 8-bit status register can be read at all times on `reg_rdata` and written through `reg_we`/`reg_wdata`. Software reads all the cause flags together to learn what reset the chip. It clears a flag by writing a zero to that bit.

Top module: `rstctl_top`

## Requirements
- R1: While any request is active, `chip_rst_n` is low with no clock edge needed. The requests are: `ext_rst_n` low, `por_det`, `wdt_timeout`, `sw_reset`, `cfg_mismatch`, `stack_full`, `stack_underflow`, or `bor_det` while `vreg_en` is high.
- R2: When a request other than power-on ends, `chip_rst_n` goes high on the 4th rising clock edge after the last edge that sampled it active, and not before.
- R3: When `por_det` ends, `chip_rst_n` stays low for at least 2048 ticks of `TICK_DIV` clocks each (the 11-bit timer), and goes high on edge 2048*`TICK_DIV`+4 after the last edge that sampled `por_det` high.
- R4: While `vreg_en` is low, `bor_det` is ignored: `chip_rst_n` stays high and no flag changes.
- R5: Status bit positions: [0] power-on, [1] brown-out, [2] watchdog, [3] external pin, [4] software reset, [5] configuration mismatch, [6] stack full or underflow, [7] interrupt-priority enable. A non-power-on request sets its own flag and leaves all other bits unchanged.
- R6: A power-on request clears every flag and bit 7, then sets only bit 0 (status reads 8'h01).
- R7: A write with `reg_we` high clears each flag bit [6:0] whose `reg_wdata` bit is 0. A 1 leaves the flag unchanged and never sets it.
- R8: Flags hold their value across later chip resets and stay set until software clears them.
- R9: Status bit 7 is a plain read/write control bit that takes `reg_wdata[7]` on every write and is not changed by non-power-on requests.
- R10: While `rst_n` is low at a clock edge, the status reads 8'h00 and `chip_rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset of the controller itself |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| por_det | input | 1 | Power-on detect pulse, asynchronous |
| bor_det | input | 1 | Brown-out detect pulse, asynchronous |
| vreg_en | input | 1 | Regulator enable; gates brown-out |
| wdt_timeout | input | 1 | Watchdog time-out, asynchronous |
| sw_reset | input | 1 | Software reset strobe |
| cfg_mismatch | input | 1 | Configuration mismatch flag |
| stack_full | input | 1 | Stack full event |
| stack_underflow | input | 1 | Stack underflow event |
| reg_we | input | 1 | Status register write strobe |
| reg_wdata | input | 8 | Status register write data |
| reg_rdata | output | 8 | Status register read data |
| chip_rst_n | output | 1 | Chip reset, active low |

## Verification
The bench builds the block with `TICK_DIV` = 4 and keeps the 11-bit timer width. This brings the full 2048-tick power-up delay down to about 8200 clocks, so the bench can bracket the release edge of `chip_rst_n` and tell a correct timer apart from one tick short or one bit narrower. Each source is then driven in turn, so that the immediate assertion of the reset, the exact 4-edge release and the accumulation of sticky flags are seen at the ports.

// File: rtl/rstctl_pkg.sv
// Package: shared source indices and status layout for the reset controller.
// Assumes: eight request sources, flag bit = source index except that both
// stack events share the last flag.
package rstctl_pkg;
    localparam int NSRC       = 8;
    localparam int NFLAG      = 7;
    localparam int SRC_POR    = 0;
    localparam int SRC_BOR    = 1;
    localparam int SRC_WDT    = 2;
    localparam int SRC_PIN    = 3;
    localparam int SRC_SW     = 4;
    localparam int SRC_CFG    = 5;
    localparam int SRC_STKFUL = 6;
    localparam int SRC_STKUND = 7;
    localparam int PRIO_BIT   = 7;
endpackage

// File: rtl/rstctl_sync.sv
// Two-stage synchroniser bank, one pair of flops per input bit.
// Assumes: each input stays stable for at least one clock period.
module rstctl_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] q1,
    output logic [W-1:0] q2
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // Pass the bit through two flops to settle metastability.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q1[i] <= 1'b0;
                q2[i] <= 1'b0;
            end else begin
                q1[i] <= din[i];
                q2[i] <= q1[i];
            end
        end
    end
endmodule

// File: rtl/rstctl_pwrt.sv
// Power-up timer: a tick divider feeding a CNT_BITS-wide counter.
// Restarts from zero on every cycle that start is high. busy drops after
// 2**CNT_BITS ticks of TICK_DIV clocks each.
module rstctl_pwrt #(
    parameter int TICK_DIV = 1600,
    parameter int CNT_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(TICK_DIV - 1);

    logic [DW-1:0]       div_q;
    logic [CNT_BITS-1:0] cnt_q;
    logic                tick;

    // Tick on the last clock of each divider period.
    always_comb tick = busy && (div_q == DIV_LAST);

    // Advance the divider and counter; start reloads both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt_q <= '0;
            busy  <= 1'b0;
        end else if (start) begin
            div_q <= '0;
            cnt_q <= '0;
            busy  <= 1'b1;
        end else if (busy) begin
            div_q <= tick ? '0 : div_q + 1'b1;
            if (tick) begin
                cnt_q <= cnt_q + 1'b1;
                if (&cnt_q) busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rstctl_flags.sv
// Status register: sticky cause flags plus one read/write priority bit.
// Assumes ev is already synchronised; events win over a same-cycle write.
module rstctl_flags
    import rstctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] ev,
    input  logic            we,
    input  logic [7:0]      wdata,
    output logic [7:0]      status
);
    logic [NFLAG-1:0] flags_q;
    logic [NFLAG-1:0] ev_flag;
    logic [NFLAG-1:0] kept;
    logic             prio_q;

    // Map sources onto flag bits; both stack events share one flag.
    always_comb begin
        ev_flag = ev[NFLAG-1:0];
        ev_flag[SRC_STKFUL] = ev[SRC_STKFUL] | ev[SRC_STKUND];
    end

    // Write-zero clears a flag, write-one keeps it.
    always_comb kept = we ? (flags_q & wdata[NFLAG-1:0]) : flags_q;

    // Update flags and priority bit; power-on overrides everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            prio_q  <= 1'b0;
        end else if (ev[SRC_POR]) begin
            flags_q <= NFLAG'(1) << SRC_POR;
            prio_q  <= 1'b0;
        end else begin
            flags_q <= kept | ev_flag;
            if (we) prio_q <= wdata[PRIO_BIT];
        end
    end

    always_comb status = {prio_q, flags_q};
endmodule

// File: rtl/rstctl_top.sv
// Reset controller top: gathers reset requests, asserts chip reset at once
// and releases it on a clock edge after the requests and the power-up timer
// are done. Assumes requests last at least one clock period.
module rstctl_top
    import rstctl_pkg::*;
#(
    parameter int TICK_DIV = 1600,
    parameter int CNT_BITS = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_rst_n,
    input  logic       por_det,
    input  logic       bor_det,
    input  logic       vreg_en,
    input  logic       wdt_timeout,
    input  logic       sw_reset,
    input  logic       cfg_mismatch,
    input  logic       stack_full,
    input  logic       stack_underflow,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       chip_rst_n
);
    logic [NSRC-1:0] raw_req;
    logic [NSRC-1:0] ev_s1;
    logic [NSRC-1:0] ev_s2;
    logic            async_req;
    logic            pwrt_busy;
    logic            hold;
    logic [1:0]      rel_q;

    // Collect requests as active-high bits; brown-out gated by regulator.
    always_comb begin
        raw_req             = '0;
        raw_req[SRC_POR]    = por_det;
        raw_req[SRC_BOR]    = bor_det & vreg_en;
        raw_req[SRC_WDT]    = wdt_timeout;
        raw_req[SRC_PIN]    = ~ext_rst_n;
        raw_req[SRC_SW]     = sw_reset;
        raw_req[SRC_CFG]    = cfg_mismatch;
        raw_req[SRC_STKFUL] = stack_full;
        raw_req[SRC_STKUND] = stack_underflow;
        async_req           = |raw_req;
    end

    rstctl_sync #(.W(NSRC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_req),
        .q1    (ev_s1),
        .q2    (ev_s2)
    );

    rstctl_pwrt #(.TICK_DIV(TICK_DIV), .CNT_BITS(CNT_BITS)) u_pwrt (
        .clk   (clk),
        .rst_n (rst_n),
        .start (ev_s2[SRC_POR]),
        .busy  (pwrt_busy)
    );

    rstctl_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev_s2),
        .we     (reg_we),
        .wdata  (reg_wdata),
        .status (reg_rdata)
    );

    // Keep reset while any request is still in the synchroniser or timer.
    always_comb hold = pwrt_busy | (|ev_s1) | (|ev_s2);

    // Assert chip reset at once, release it through two clocked stages.
    always_ff @(posedge clk or posedge async_req) begin
        if (async_req)   rel_q <= 2'b00;
        else if (!rst_n) rel_q <= 2'b00;
        else             rel_q <= {rel_q[0], ~hold};
    end

    assign chip_rst_n = rel_q[1];
endmodule

// File: rtl/rstctl_checker.sv
// Checker for rstctl_top: temporal properties on reset and status behaviour.
module rstctl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       async_req,
    input logic       pwrt_busy,
    input logic [7:0] ev_s2,
    input logic       reg_we,
    input logic [7:0] reg_rdata,
    input logic       chip_rst_n
);
    p_req_holds_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        async_req |-> !chip_rst_n);

    p_timer_holds_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pwrt_busy |-> !chip_rst_n);

    p_por_sets_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_s2[0] |=> (reg_rdata == 8'h01));

    p_write_never_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && ev_s2 == 8'h00) |=> ((reg_rdata[6:0] & ~$past(reg_rdata[6:0])) == 7'h00));

    p_flags_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_we && ev_s2 == 8'h00) |=> $stable(reg_rdata));
endmodule

bind rstctl_top rstctl_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .async_req  (async_req),
    .pwrt_busy  (pwrt_busy),
    .ev_s2      (ev_s2),
    .reg_we     (reg_we),
    .reg_rdata  (reg_rdata),
    .chip_rst_n (chip_rst_n)
);

// File: tb/rstctl_top_test.sv
// Directed bench for rstctl_top: one task per scenario, each self-checking.
module rstctl_top_test;
    localparam int DIV = 4;
    localparam int NTICK = 2048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       por_det = 1'b0;
    logic       bor_det = 1'b0;
    logic       vreg_en = 1'b1;
    logic       wdt_timeout = 1'b0;
    logic       sw_reset = 1'b0;
    logic       cfg_mismatch = 1'b0;
    logic       stack_full = 1'b0;
    logic       stack_underflow = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       chip_rst_n;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_st = 8'h00;

    always #2.5 clk = ~clk;

    rstctl_top #(.TICK_DIV(DIV), .CNT_BITS(11)) uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .ext_rst_n       (ext_rst_n),
        .por_det         (por_det),
        .bor_det         (bor_det),
        .vreg_en         (vreg_en),
        .wdt_timeout     (wdt_timeout),
        .sw_reset        (sw_reset),
        .cfg_mismatch    (cfg_mismatch),
        .stack_full      (stack_full),
        .stack_underflow (stack_underflow),
        .reg_we          (reg_we),
        .reg_wdata       (reg_wdata),
        .reg_rdata       (reg_rdata),
        .chip_rst_n      (chip_rst_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_src(input int idx, input logic on);
        case (idx)
            1: bor_det = on;
            2: wdt_timeout = on;
            3: ext_rst_n = ~on;
            4: sw_reset = on;
            5: cfg_mismatch = on;
            6: stack_full = on;
            7: stack_underflow = on;
            default: por_det = on;
        endcase
    endtask

    // R10: reset state of the controller.
    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk("R10 status", reg_rdata, 8'h00);
        chk("R10 chip_rst_n", chip_rst_n, 1'b0);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    // R3, R6: power-on reset and power-up timer length.
    task automatic t_por();
        @(negedge clk);
        por_det = 1'b1;
        #1 chk("R1 por immediate", chip_rst_n, 1'b0);
        repeat (3) @(negedge clk);
        por_det = 1'b0;
        repeat (NTICK * DIV) @(negedge clk);
        chk("R3 still held", chip_rst_n, 1'b0);
        repeat (6) @(negedge clk);
        chk("R3 released", chip_rst_n, 1'b1);
        exp_st = 8'h01;
        chk("R6 status", reg_rdata, exp_st);
    endtask

    // R1, R2, R5, R8: a non-power-on source.
    task automatic t_src(input int idx, input int flag);
        @(negedge clk);
        drive_src(idx, 1'b1);
        #1 chk("R1 immediate", chip_rst_n, 1'b0);
        repeat (3) @(negedge clk);
        drive_src(idx, 1'b0);
        repeat (3) @(negedge clk);
        chk("R2 low at edge 3", chip_rst_n, 1'b0);
        @(negedge clk);
        chk("R2 high at edge 4", chip_rst_n, 1'b1);
        exp_st[flag] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R5 R8 status", reg_rdata, exp_st);
    endtask

    // R7, R9: status write.
    task automatic t_write(input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        exp_st = {d[7], exp_st[6:0] & d[6:0]};
        chk("R7 R9 after write", reg_rdata, exp_st);
    endtask

    // R4: brown-out ignored while regulator disabled.
    task automatic t_bor_gated();
        @(negedge clk);
        vreg_en = 1'b0;
        bor_det = 1'b1;
        #1 chk("R4 no reset", chip_rst_n, 1'b1);
        repeat (4) @(negedge clk);
        chk("R4 no reset held", chip_rst_n, 1'b1);
        bor_det = 1'b0;
        repeat (4) @(negedge clk);
        chk("R4 flags unchanged", reg_rdata, exp_st);
        vreg_en = 1'b1;
    endtask

    initial begin
        t_reset();
        t_por();
        t_write(8'h80);            // R9 set priority bit
        t_src(2, 2);               // watchdog
        t_src(3, 3);               // pin
        t_src(4, 4);               // software
        t_write(8'hFF);            // R7 ones change nothing, bit7 stays 1
        t_src(5, 5);               // config mismatch
        t_src(6, 6);               // stack full
        t_write(8'hBF);            // R7 clear stack flag only
        t_src(7, 6);               // stack underflow
        t_bor_gated();
        t_src(1, 1);               // brown-out with regulator on
        t_write(8'h7B);            // R7 R9 clear wdt flag and priority
        t_por();                   // R6 clears everything else
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule